// File: doc/BRIEF.md
# GPIO Pin Configuration Guard

This block is the configuration register set for one GPIO port of eight pins. It stores, per pin, four configuration bits: alternate-function enable, pull-up enable, pull-down enable and digital enable. It drives these bits straight out to the pad and mux logic. Some pins carry sensitive functions, such as a debug port or a non-maskable interrupt input. These pins are marked by a parameter mask and are guarded so that a stray software write cannot reconfigure them.

Every write to a configuration register is masked bit by bit by a commit register. Commit bits of ordinary pins are fixed at one, so those pins can always be reconfigured. Commit bits of guarded pins reset to zero. Software can set them only after it has opened a key register with an exact 32-bit key. A guarded pin therefore starts with no alternate function and no digital enable. It becomes active only after a deliberate sequence of three writes: open the key register, set the commit bit, then write the configuration register.

Software reaches the block through a simple register bus: word address, write data, write enable and combinational read data.

Top module: `gcg_top`

## Requirements
- R1: After reset the four configuration registers read 0. The key register reads 1 (closed). The commit register reads ones on ordinary pins and zeros on guarded pins (0x7E with the default mask 0x81).
- R2: Commit bits of ordinary pins always read 1. Writing 0 to them changes nothing, whether the key register is open or closed.
- R3: A write to a configuration register changes only the bits whose commit bit is 1. All other bits keep their previous value.
- R4: Writing exactly 0x4C4F434B to the key register opens it. Any other value, including values one bit away from the key, closes it. A read returns 1 in bit 0 while closed and 0 while open.
- R5: Closing the key register with a non-key write leaves the commit bits unchanged.
- R6: While the key register is closed, writes to the commit register are ignored.
- R7: A guarded pin's alternate function and digital enable reach the outputs only after the sequence: open the key register, set its commit bit, write the configuration register.
- R8: Word addresses 0x6 to 0xF read 0 and ignore writes. The register at word address 0x0 holds the alternate-function enables, 0x1 the pull-ups, 0x2 the pull-downs, 0x3 the digital enables, 0x4 the key state and 0x5 the commit bits. Pin n maps to data bit n.
- R9: Read data bits above the pin count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current address |
| cfg_afsel | output | 8 | Alternate-function enable per pin |
| cfg_pullup | output | 8 | Pull-up enable per pin |
| cfg_pulldn | output | 8 | Pull-down enable per pin |
| cfg_den | output | 8 | Digital enable per pin |

## Verification
The bench builds the block at its default size: eight pins, guard mask 0x81, and a four-bit address that covers both mapped and unmapped words. With only eight pins, every write value can be swept into each configuration register, and every commit value can be tried. This reaches every combination of guarded and ordinary bits in the write masking. The full address space is reread after each step, so a write that lands on the wrong register or an unmapped word is seen at once.

// File: rtl/gcg_pkg.sv
`timescale 1ns/1ps
package gcg_pkg;

  // Register word addresses; the bus decode and readback depend on them.
  localparam int REG_AFSEL  = 0;
  localparam int REG_PULLUP = 1;
  localparam int REG_PULLDN = 2;
  localparam int REG_DEN    = 3;
  localparam int REG_LOCK   = 4;
  localparam int REG_COMMIT = 5;
  localparam int NCFG       = 4;

  // Bits of cur selected by en are replaced by nxt; others are kept.
  function automatic logic [31:0] masked_merge(input logic [31:0] cur,
                                               input logic [31:0] nxt,
                                               input logic [31:0] en);
    return (cur & ~en) | (nxt & en);
  endfunction

  // Commit value that results from a write: guarded bits take the data,
  // ordinary bits are forced high.
  function automatic logic [31:0] commit_value(input logic [31:0] data,
                                               input logic [31:0] guard);
    return (data & guard) | ~guard;
  endfunction

endpackage

// File: rtl/gcg_lock.sv
`timescale 1ns/1ps
module gcg_lock #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h4C4F434B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              unlock_evt,
  output logic              relock_evt
);
  logic key_match;

  assign key_match  = (wdata == DATA_W'(KEY));
  assign unlock_evt = wr_lock & key_match;
  assign relock_evt = wr_lock & ~key_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b1;
    else if (unlock_evt) locked <= 1'b0;
    else if (relock_evt) locked <= 1'b1;
  end
endmodule

// File: rtl/gcg_commit.sv
`timescale 1ns/1ps
module gcg_commit #(
  parameter int               NPINS = 8,
  parameter logic [NPINS-1:0] GUARD = 8'h81
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_commit,
  input  logic             locked,
  input  logic [NPINS-1:0] wbits,
  output logic [NPINS-1:0] commit,
  output logic             commit_drop
);
  logic             take;
  logic [31:0]      merged;

  assign take        = wr_commit & ~locked;
  assign commit_drop = wr_commit & locked;
  assign merged      = gcg_pkg::commit_value(32'(wbits), 32'(GUARD));

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    if (GUARD[i]) begin : g_guarded
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bit_q <= 1'b0;
        else if (take) bit_q <= merged[i];
      end
      assign commit[i] = bit_q;
    end else begin : g_open
      assign commit[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gcg_cfg_bank.sv
`timescale 1ns/1ps
module gcg_cfg_bank #(
  parameter int NPINS = 8,
  parameter int NREG  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            wr_sel,
  input  logic [NPINS-1:0]           commit,
  input  logic [NPINS-1:0]           wbits,
  output logic [NREG-1:0][NPINS-1:0] q
);
  logic [31:0] nxt [NREG];

  always_comb begin
    for (int g = 0; g < NREG; g++)
      nxt[g] = gcg_pkg::masked_merge(32'(q[g]), 32'(wbits), 32'(commit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int g = 0; g < NREG; g++)
        if (wr_sel[g]) q[g] <= nxt[g][NPINS-1:0];
    end
  end
endmodule

// File: rtl/gcg_rdmux.sv
`timescale 1ns/1ps
module gcg_rdmux #(
  parameter int NPINS  = 8,
  parameter int NREG   = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NREG-1:0][NPINS-1:0] cfg,
  input  logic                       locked,
  input  logic [NPINS-1:0]           commit,
  output logic [DATA_W-1:0]          rd_data
);
  always_comb begin
    rd_data = '0;
    if (addr < ADDR_W'(NREG))
      rd_data = DATA_W'(cfg[addr[$clog2(NREG)-1:0]]);
    else if (addr == ADDR_W'(gcg_pkg::REG_LOCK))
      rd_data = DATA_W'(locked);
    else if (addr == ADDR_W'(gcg_pkg::REG_COMMIT))
      rd_data = DATA_W'(commit);
  end
endmodule

// File: rtl/gcg_top.sv
`timescale 1ns/1ps
module gcg_top #(
  parameter int               NPINS  = 8,
  parameter logic [NPINS-1:0] GUARD  = 8'h81,
  parameter int               ADDR_W = 4,
  parameter int               DATA_W = 32,
  parameter logic [31:0]      KEY    = 32'h4C4F434B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [NPINS-1:0]  cfg_afsel,
  output logic [NPINS-1:0]  cfg_pullup,
  output logic [NPINS-1:0]  cfg_pulldn,
  output logic [NPINS-1:0]  cfg_den
);
  localparam int NREG = gcg_pkg::NCFG;

  logic                       wr_lock, wr_commit;
  logic [NREG-1:0]            cfg_wr_sel;
  logic                       locked, unlock_evt, relock_evt, commit_drop;
  logic [NPINS-1:0]           commit;
  logic [NREG-1:0][NPINS-1:0] cfg_q;

  assign wr_lock   = wr_en && (addr == ADDR_W'(gcg_pkg::REG_LOCK));
  assign wr_commit = wr_en && (addr == ADDR_W'(gcg_pkg::REG_COMMIT));

  for (genvar r = 0; r < NREG; r++) begin : g_sel
    assign cfg_wr_sel[r] = wr_en && (addr == ADDR_W'(r));
  end

  gcg_lock #(.DATA_W(DATA_W), .KEY(KEY)) lock_i (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .wdata(wdata),
    .locked(locked), .unlock_evt(unlock_evt), .relock_evt(relock_evt)
  );

  gcg_commit #(.NPINS(NPINS), .GUARD(GUARD)) commit_i (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .locked(locked),
    .wbits(wdata[NPINS-1:0]), .commit(commit), .commit_drop(commit_drop)
  );

  gcg_cfg_bank #(.NPINS(NPINS), .NREG(NREG)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(cfg_wr_sel), .commit(commit),
    .wbits(wdata[NPINS-1:0]), .q(cfg_q)
  );

  gcg_rdmux #(.NPINS(NPINS), .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rdmux_i (
    .addr(addr), .cfg(cfg_q), .locked(locked), .commit(commit), .rd_data(rd_data)
  );

  assign cfg_afsel  = cfg_q[gcg_pkg::REG_AFSEL];
  assign cfg_pullup = cfg_q[gcg_pkg::REG_PULLUP];
  assign cfg_pulldn = cfg_q[gcg_pkg::REG_PULLDN];
  assign cfg_den    = cfg_q[gcg_pkg::REG_DEN];
endmodule

// File: rtl/gcg_chk.sv
`timescale 1ns/1ps
module gcg_chk #(
  parameter int          NPINS  = 8,
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h4C4F434B
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              locked,
  input logic              unlock_evt,
  input logic              relock_evt,
  input logic              commit_drop,
  input logic [NPINS-1:0]  commit,
  input logic [NPINS-1:0]  cfg_afsel,
  input logic [NPINS-1:0]  cfg_pullup,
  input logic [NPINS-1:0]  cfg_pulldn,
  input logic [NPINS-1:0]  cfg_den
);
  logic lock_hit, unmapped;
  assign lock_hit = wr_en && (addr == ADDR_W'(gcg_pkg::REG_LOCK));
  assign unmapped = addr > ADDR_W'(gcg_pkg::REG_COMMIT);

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && wdata == DATA_W'(KEY)) |=> !locked); // R4
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    relock_evt |=> (locked && $stable(commit))); // R5
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({unlock_evt, relock_evt}) == (lock_hit ? 1 : 0)); // R4
  AST_CLOSED_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_drop |=> $stable(commit)); // R6
  AST_AFSEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cfg_afsel ^ $past(cfg_afsel)) & ~$past(commit)) == '0)); // R3
  AST_DEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cfg_den ^ $past(cfg_den)) & ~$past(commit)) == '0)); // R3
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> rd_data == '0); // R8
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> ($stable(commit) && $stable(locked) && $stable(cfg_afsel)
      && $stable(cfg_pullup) && $stable(cfg_pulldn) && $stable(cfg_den))); // R8
endmodule

bind gcg_top gcg_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_data(rd_data), .locked(locked), .unlock_evt(unlock_evt),
  .relock_evt(relock_evt), .commit_drop(commit_drop), .commit(commit),
  .cfg_afsel(cfg_afsel), .cfg_pullup(cfg_pullup), .cfg_pulldn(cfg_pulldn),
  .cfg_den(cfg_den)
);

// File: tb/gcg_top_tb_top.sv
`timescale 1ns/1ps
module gcg_top_tb_top;
  localparam logic [7:0]  GUARD_TB = 8'h81;
  localparam logic [7:0]  OPEN_TB  = ~GUARD_TB;
  localparam logic [31:0] KEY_TB   = 32'h4C4F434B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [7:0]  cfg_afsel, cfg_pullup, cfg_pulldn, cfg_den;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the register state
  logic [7:0] m_cfg [4];
  logic [7:0] m_commit;
  logic       m_closed;

  always #2 clk = ~clk;

  gcg_top #(.NPINS(8), .GUARD(GUARD_TB), .ADDR_W(4), .DATA_W(32), .KEY(KEY_TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_data(rd_data), .cfg_afsel(cfg_afsel), .cfg_pullup(cfg_pullup),
    .cfg_pulldn(cfg_pulldn), .cfg_den(cfg_den)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input int a);
    if (a < 4)  return {24'h0, m_cfg[a]};
    if (a == 4) return {31'h0, m_closed};
    if (a == 5) return {24'h0, m_commit};
    return 32'h0;
  endfunction

  // bench's own statement of the register behaviour
  task automatic model_write(input int a, input logic [31:0] d);
    if (a < 4) begin
      for (int b = 0; b < 8; b++)
        if (m_commit[b]) m_cfg[a][b] = d[b];
    end else if (a == 4) begin
      m_closed = (d != KEY_TB);
    end else if (a == 5 && !m_closed) begin
      for (int b = 0; b < 8; b++)
        m_commit[b] = GUARD_TB[b] ? d[b] : 1'b1;
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_check(input string req, input int a);
    addr = 4'(a);
    #1;
    check(req, rd_data, expect_word(a));
  endtask

  task automatic outputs_check(input string req);
    #1;
    check(req, {cfg_den, cfg_pulldn, cfg_pullup, cfg_afsel},
          {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]});
  endtask

  task automatic sweep_reads(input string req);
    for (int a = 0; a < 16; a++) read_check(req, a);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) m_cfg[r] = 8'h00;
    m_commit = OPEN_TB;
    m_closed = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R9: reset state over the full address space
    sweep_reads("R1");
    check("R1 commit", rd_data, 32'h0);
    read_check("R1", 5);
    check("R1 commit value", {24'h0, m_commit}, 32'h7E);
    outputs_check("R1");

    // R6: commit write while closed is dropped
    bus_write(5, 32'hFF);
    read_check("R6", 5);
    // R2: open, try to clear ordinary commit bits
    bus_write(4, KEY_TB);
    read_check("R4 open", 4);
    bus_write(5, 32'h00);
    read_check("R2", 5);
    bus_write(4, 32'h0);
    read_check("R2 closed", 5);
    bus_write(5, 32'h00);
    read_check("R2", 5);

    // R3: every value into every config register under the reset commit mask
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 256; v++) begin
        bus_write(r, {24'hFFFFFF, 8'(v)});
        read_check("R3", r);
        outputs_check("R3");
      end

    // R4: exact key only; single-bit neighbours close it
    for (int b = 0; b < 32; b++) begin
      bus_write(4, KEY_TB);
      read_check("R4 key", 4);
      bus_write(4, KEY_TB ^ (32'h1 << b));
      read_check("R4 near key", 4);
    end

    // R5: closing keeps commit bits
    bus_write(4, KEY_TB);
    bus_write(5, 32'h81);
    read_check("R5 set", 5);
    bus_write(4, 32'h12345678);
    read_check("R5", 5);
    read_check("R5 closed", 4);
    bus_write(5, 32'h00);
    read_check("R6", 5);

    // R3, R2: every commit value, then set and clear every config register
    for (int c = 0; c < 256; c++) begin
      bus_write(4, KEY_TB);
      bus_write(5, 32'(c));
      read_check("R2 commit sweep", 5);
      bus_write(4, 32'h0);
      bus_write(c % 4, 32'hFF);
      read_check("R3 commit sweep", c % 4);
      bus_write(c % 4, 32'h00);
      read_check("R3 commit sweep", c % 4);
      outputs_check("R3 commit sweep");
    end

    // R7: guarded pin 0 gets alternate function only via full sequence
    bus_write(4, KEY_TB);
    bus_write(5, 32'h00);
    bus_write(4, 32'h0);
    bus_write(0, 32'h00);
    bus_write(3, 32'h00);
    bus_write(0, 32'h01);
    bus_write(3, 32'h01);
    check("R7 blocked", {16'h0, cfg_den, cfg_afsel}, 32'h0);
    bus_write(5, 32'h01);
    bus_write(0, 32'h01);
    check("R7 closed commit", {24'h0, cfg_afsel}, 32'h0);
    bus_write(4, KEY_TB);
    bus_write(5, 32'h01);
    bus_write(4, 32'h0);
    bus_write(0, 32'h01);
    bus_write(3, 32'h01);
    #1;
    check("R7 enabled", {16'h0, cfg_den, cfg_afsel}, 32'h0101);
    outputs_check("R7");

    // R8: unmapped words read 0 and ignore writes
    for (int a = 6; a < 16; a++) begin
      bus_write(a, 32'hFFFFFFFF);
      sweep_reads("R8");
      outputs_check("R8");
    end
    bus_write(15, KEY_TB);
    read_check("R8 no open", 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule